// File: doc/BRIEF.md
# Pixel Hit Latch Array with Gray-Coded Time Step

This block is a two-dimensional array of binary pixel cells together with the shared time-step counter that sits at the array's edge. A bunch train starts with a global clear. During the train, every strobe on the time-step input moves the counter one step on. The counter's value is presented in Gray code and fanned out to every pixel. Each pixel watches its own discriminator hit line and its own test-pulse line. The first event on either line sets a sticky hit flag and stores the Gray code present in that cycle. The flag and the stored code stay put until the next clear. An OR reduction across all flags tells the readout logic whether any pixel holds data.

The counter is a two-state machine. In `TMR_COUNT` a strobe increments the binary count; this transition is named T_STEP. The strobe that reaches the last count takes transition T_SATURATE into `TMR_HOLD`, where further strobes are ignored. A clear or reset from either state returns it to `TMR_COUNT` at count zero; this transition is named T_CLEAR.

Each pixel is also a two-state machine. `PIX_EMPTY` moves to `PIX_HELD` on a hit or test event, and this transition (T_CAPTURE) loads the timestamp. In `PIX_HELD`, further events take the self-loop T_IGNORE and change nothing. A clear moves the pixel back to `PIX_EMPTY` (T_CLEAR).

Top module: `pxl_hit_array`

## Requirements
- R1: A hit on a pixel in state `PIX_EMPTY`, sampled at a rising clock edge, sets that pixel's flag after that edge. The same edge stores in the pixel the Gray code shown on `time_code` during that cycle.
- R2: Once a pixel's flag is set, later hit or test events in the same train leave its stored timestamp unchanged.
- R3: A set flag stays high on every following cycle until a clear or reset.
- R4: A test pulse on a pixel has exactly the same effect as a discriminator hit on that pixel.
- R5: `train_clr` high at a rising edge zeroes every flag, every stored timestamp and the counter, so `time_code` reads 0. The clear wins over any hit, test pulse or strobe in the same cycle.
- R6: Each strobe in `TMR_COUNT` adds one to the binary count. `time_code` equals b XOR (b >> 1) for count b, so two successive codes differ in exactly one bit.
- R7: Once the count reaches its maximum, 2^TSW-1, further strobes leave `time_code` fixed at that count's Gray code until a clear. With TSW=4 that code is binary 1000.
- R8: `any_hit` is high in exactly the cycles in which at least one pixel flag is high.
- R9: `rst_n` low clears flags, timestamps and the counter at once, without waiting for a clock edge.
- R10: Pixel p sits at row r = p / COLS and column c = p % COLS. Its hit and test inputs are bit p of `hit_in` and `test_in`. Its flag is bit p of `hit_flags`, and its timestamp is bits [p*TSW +: TSW] of `stamps`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_clr | input | 1 | Synchronous clear that starts a new bunch train |
| step_stb | input | 1 | Time-step strobe; advances the counter by one |
| hit_in | input | ROWS*COLS | Discriminator hit per pixel |
| test_in | input | ROWS*COLS | Test pulse per pixel |
| time_code | output | TSW | Current Gray-coded time step |
| hit_flags | output | ROWS*COLS | Sticky hit flag per pixel |
| stamps | output | ROWS*COLS*TSW | Stored Gray timestamp per pixel |
| any_hit | output | 1 | OR of all hit flags |

## Verification
The hardest case to create from the ports is a set of distinct stored timestamps spread across the whole array. It is equally hard to show that held pixels then ignore a second wave of events. A small array is used, and the counter is stepped to a different time step before each pixel is struck, alternating between the hit line and the test line. As a result, every pixel holds its own expected code. Every pixel is then struck again at a later step, and each stored code is compared with its original value. The sweep continues into saturation. The train ends with a clear that arrives together with a hit and a strobe, so the bench can confirm that the clear takes priority.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    typedef enum logic [0:0] {
        TMR_COUNT = 1'b0,
        TMR_HOLD  = 1'b1
    } tmr_state_t;

    typedef enum logic [0:0] {
        PIX_EMPTY = 1'b0,
        PIX_HELD  = 1'b1
    } pix_state_t;
endpackage

// File: rtl/pxl_gray_timer.sv
module pxl_gray_timer
    import pxl_pkg::*;
#(
    parameter int TSW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           train_clr,
    input  logic           step_stb,
    output logic [TSW-1:0] gray_o
);
    localparam logic [TSW-1:0] LAST_BIN = {TSW{1'b1}};

    tmr_state_t     state, state_nxt;
    logic [TSW-1:0] bin, bin_nxt;

    always_comb begin
        state_nxt = state;
        bin_nxt   = bin;
        if (train_clr) begin
            state_nxt = TMR_COUNT;           // T_CLEAR
            bin_nxt   = '0;
        end else begin
            unique case (state)
                TMR_COUNT: begin
                    if (step_stb) begin
                        bin_nxt = bin + 1'b1;      // T_STEP
                        if (bin_nxt == LAST_BIN) begin
                            state_nxt = TMR_HOLD;  // T_SATURATE
                        end
                    end
                end
                TMR_HOLD: begin
                    state_nxt = TMR_HOLD;
                end
                default: state_nxt = TMR_COUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMR_COUNT;
            bin   <= '0;
        end else begin
            state <= state_nxt;
            bin   <= bin_nxt;
        end
    end

    always_comb begin
        gray_o = bin ^ (bin >> 1);
    end

    // R6: a strobe while counting moves the code by exactly one bit
    a_r6_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_stb && !train_clr && state == TMR_COUNT) |=>
            ($countones(gray_o ^ $past(gray_o)) == 1));

    // R7: saturated counter holds its code
    a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMR_HOLD && !train_clr) |=> $stable(gray_o));

    // R6: without a strobe or clear the code does not move
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_stb && !train_clr) |=> $stable(gray_o));

    // R5: clear returns the code to zero
    a_r5_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        train_clr |=> (gray_o == '0));
endmodule

// File: rtl/pxl_cell.sv
module pxl_cell
    import pxl_pkg::*;
#(
    parameter int TSW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           train_clr,
    input  logic           hit_i,
    input  logic           test_i,
    input  logic [TSW-1:0] time_i,
    output logic           flag_o,
    output logic [TSW-1:0] stamp_o
);
    pix_state_t     state, state_nxt;
    logic [TSW-1:0] stamp_q, stamp_nxt;
    logic           event_in;

    always_comb begin
        event_in  = hit_i | test_i;
        state_nxt = state;
        stamp_nxt = stamp_q;
        if (train_clr) begin
            state_nxt = PIX_EMPTY;          // T_CLEAR
            stamp_nxt = '0;
        end else begin
            unique case (state)
                PIX_EMPTY: begin
                    if (event_in) begin
                        state_nxt = PIX_HELD;  // T_CAPTURE
                        stamp_nxt = time_i;
                    end
                end
                PIX_HELD: begin
                    state_nxt = PIX_HELD;      // T_IGNORE
                end
                default: state_nxt = PIX_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PIX_EMPTY;
            stamp_q <= '0;
        end else begin
            state   <= state_nxt;
            stamp_q <= stamp_nxt;
        end
    end

    always_comb begin
        flag_o  = (state == PIX_HELD);
        stamp_o = stamp_q;
    end

    // R3: a held flag persists until clear
    a_r3_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !train_clr) |=> flag_o);

    // R2: a held pixel keeps its timestamp
    a_r2_stamp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !train_clr) |=> $stable(stamp_o));

    // R1: first event captures the time code
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !train_clr && (hit_i || test_i)) |=>
            (flag_o && stamp_o == $past(time_i)));

    // R5: clear empties the pixel
    a_r5_clear_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        train_clr |=> (!flag_o && stamp_o == '0));
endmodule

// File: rtl/pxl_row.sv
module pxl_row #(
    parameter int COLS = 64,
    parameter int TSW  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                train_clr,
    input  logic [COLS-1:0]     hit_i,
    input  logic [COLS-1:0]     test_i,
    input  logic [TSW-1:0]      time_i,
    output logic [COLS-1:0]     flags_o,
    output logic [COLS*TSW-1:0] stamps_o,
    output logic                row_any_o
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        pxl_cell #(.TSW(TSW)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .train_clr (train_clr),
            .hit_i     (hit_i[c]),
            .test_i    (test_i[c]),
            .time_i    (time_i),
            .flag_o    (flags_o[c]),
            .stamp_o   (stamps_o[c*TSW +: TSW])
        );
    end

    always_comb begin
        row_any_o = |flags_o;
    end
endmodule

// File: rtl/pxl_hit_array.sv
module pxl_hit_array #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int TSW  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       train_clr,
    input  logic                       step_stb,
    input  logic [ROWS*COLS-1:0]       hit_in,
    input  logic [ROWS*COLS-1:0]       test_in,
    output logic [TSW-1:0]             time_code,
    output logic [ROWS*COLS-1:0]       hit_flags,
    output logic [ROWS*COLS*TSW-1:0]   stamps,
    output logic                       any_hit
);
    localparam int ROW_BITS  = COLS;
    localparam int ROW_SBITS = COLS * TSW;

    logic [ROWS-1:0] row_any;

    pxl_gray_timer #(.TSW(TSW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .train_clr (train_clr),
        .step_stb  (step_stb),
        .gray_o    (time_code)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        pxl_row #(.COLS(COLS), .TSW(TSW)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .train_clr (train_clr),
            .hit_i     (hit_in[r*ROW_BITS +: ROW_BITS]),
            .test_i    (test_in[r*ROW_BITS +: ROW_BITS]),
            .time_i    (time_code),
            .flags_o   (hit_flags[r*ROW_BITS +: ROW_BITS]),
            .stamps_o  (stamps[r*ROW_SBITS +: ROW_SBITS]),
            .row_any_o (row_any[r])
        );
    end

    always_comb begin
        any_hit = |row_any;
    end

    // R8 / R5: after a clear nothing reports data
    a_r8_clear_any: assert property (@(posedge clk) disable iff (!rst_n)
        train_clr |=> !any_hit);

    // R8: once data is present and no clear comes, it remains reported
    a_r8_any_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !train_clr) |=> any_hit);
endmodule

// File: tb/tb_pxl_hit_array.sv
module tb_pxl_hit_array;
    localparam int CLK_P = 10;
    localparam int ROWS  = 2;
    localparam int COLS  = 3;
    localparam int TSW   = 4;
    localparam int NP    = ROWS * COLS;
    localparam int MAXB  = (1 << TSW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 train_clr = 1'b0;
    logic                 step_stb = 1'b0;
    logic [NP-1:0]        hit_in = '0;
    logic [NP-1:0]        test_in = '0;
    logic [TSW-1:0]       time_code;
    logic [NP-1:0]        hit_flags;
    logic [NP*TSW-1:0]    stamps;
    logic                 any_hit;

    int n_chk = 0;
    int n_fail = 0;
    int bin_exp = 0;
    int exp_stamp [NP];
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pxl_hit_array #(.ROWS(ROWS), .COLS(COLS), .TSW(TSW)) dut (
        .clk(clk), .rst_n(rst_n), .train_clr(train_clr), .step_stb(step_stb),
        .hit_in(hit_in), .test_in(test_in), .time_code(time_code),
        .hit_flags(hit_flags), .stamps(stamps), .any_hit(any_hit)
    );

    function automatic int gray(int b);
        return (b ^ (b >> 1)) & MAXB;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int stamp_of(int p);
        return int'(stamps[p*TSW +: TSW]);
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe();
        int prev;
        prev = int'(time_code);
        step_stb = 1'b1;
        cycle();
        step_stb = 1'b0;
        if (bin_exp < MAXB) bin_exp++;
        chk("R6 code", int'(time_code), gray(bin_exp));
        if (bin_exp < MAXB || prev != gray(MAXB))
            chk("R6 one-bit step", $countones(prev ^ int'(time_code)), 1);
        else
            chk("R7 saturated", int'(time_code), prev);
    endtask

    task automatic strike(int p, bit use_test);
        if (use_test) test_in[p] = 1'b1; else hit_in[p] = 1'b1;
        cycle();
        test_in = '0;
        hit_in = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 flags at reset", int'(hit_flags), 0);
        chk("R9 stamps at reset", int'(stamps), 0);
        chk("R9 code at reset", int'(time_code), 0);
        chk("R8 any_hit at reset", int'(any_hit), 0);
        rst_n = 1'b1;
        cycle();

        // R1 / R4 / R10: pixel p struck at step 2p, odd pixels via test line
        for (int p = 0; p < NP; p++) begin
            while (bin_exp < 2 * p) strobe();
            exp_stamp[p] = gray(bin_exp);
            strike(p, p[0]);
            chk(p[0] ? "R4 test flag" : "R1 hit flag", int'(hit_flags[p]), 1);
            chk(p[0] ? "R4 test stamp" : "R1 hit stamp", stamp_of(p), exp_stamp[p]);
            chk("R10 only own flag", int'(hit_flags), (1 << (p + 1)) - 1);
            chk("R8 any_hit set", int'(any_hit), 1);
        end

        // R2 / R3: second wave of events changes nothing
        strobe();
        for (int p = 0; p < NP; p++) strike(p, ~p[0]);
        hit_in = '1; test_in = '1;
        strobe();
        hit_in = '0; test_in = '0;
        for (int p = 0; p < NP; p++) begin
            chk("R2 stamp unchanged", stamp_of(p), exp_stamp[p]);
            chk("R3 flag held", int'(hit_flags[p]), 1);
        end

        // R6 / R7: run to the end and beyond
        while (bin_exp < MAXB) strobe();
        chk("R7 final code", int'(time_code), gray(MAXB));
        for (int k = 0; k < 4; k++) strobe();
        chk("R7 held after extra strobes", int'(time_code), gray(MAXB));
        chk("R3 flags through saturation", int'(hit_flags), (1 << NP) - 1);

        // R5: clear wins over simultaneous hit, test and strobe
        train_clr = 1'b1; step_stb = 1'b1; hit_in[0] = 1'b1; test_in[NP-1] = 1'b1;
        cycle();
        train_clr = 1'b0; step_stb = 1'b0; hit_in = '0; test_in = '0;
        bin_exp = 0;
        chk("R5 flags cleared", int'(hit_flags), 0);
        chk("R5 stamps cleared", int'(stamps), 0);
        chk("R5 code cleared", int'(time_code), 0);
        chk("R8 any_hit cleared", int'(any_hit), 0);

        // R1 in new train at code 0, then R4 at step 1
        strike(2, 1'b0);
        chk("R1 capture at code 0", stamp_of(2), 0);
        chk("R1 flag new train", int'(hit_flags), 4);
        strobe();
        strike(NP - 1, 1'b1);
        chk("R4 test capture step 1", stamp_of(NP - 1), gray(1));
        strobe();
        strobe();
        chk("R6 code after restart", int'(time_code), gray(3));

        // R9: asynchronous reset between edges
        #(CLK_P/4);
        rst_n = 1'b0;
        #1;
        chk("R9 async flags", int'(hit_flags), 0);
        chk("R9 async code", int'(time_code), 0);
        chk("R9 async any_hit", int'(any_hit), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule